// File: doc/BRIEF.md
# 32-bit GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port that software controls through a small word-addressed register bus. Each pin has an output latch, a direction bit and a synchronised view of its pad. Software reads the pad view through a dedicated status word. The data word returns the pad level for input pins and the latched value for output pins.

Each pin also has an interrupt detector. A 2-bit field selects how the pin triggers. The fields for pins 0 to 15 sit in the lower configuration word and those for pins 16 to 31 in the upper word. A detected event sets a sticky status bit, and software clears that bit by writing a one to it. A level trigger whose condition still holds sets the bit again on the next cycle. Because the configuration resets to low-level detection, any pin held low after reset shows a pending status bit. A per-pin mask gates the status bits onto one combined interrupt line. The status bits are still captured while their mask bits are 0.

Top module: `gpio_port`

## Requirements
- R1: The registers sit at these byte addresses: output latch 0x00, direction 0x04, pad status 0x08 (read-only), trigger configuration for pins 0–15 at 0x0C, trigger configuration for pins 16–31 at 0x10, mask 0x14, and event status 0x18. Every register reads 0 during reset.
- R2: `pad_oe` always equals the direction register and `pad_out` always equals the output latch. The direction register resets to 0, so all pins start as inputs.
- R3: Reading 0x08 returns the pad input after a two-flop synchroniser, whatever the direction setting.
- R4: Reading 0x00 returns, bit by bit, the synchronised pad level where direction is 0 and the latched value where direction is 1.
- R5: The mask register resets to 0, and only a bus write to 0x14 changes it.
- R6: Pin i uses bits [2i+1:2i] of the 64-bit concatenation {upper word, lower word}. The encodings are 00 low level, 01 high level, 10 rising edge and 11 falling edge. The reset value 00 means a pin held low sets its status bit.
- R7: Writing a 1 to a status bit at 0x18 clears it, and writing a 0 leaves it unchanged. If an event and a clear reach the same bit in one cycle, the event wins, so a level trigger that still holds reads back as 1.
- R8: `irq` is high exactly when some status bit and its mask bit are both 1. Status bits are captured even when their mask bit is 0.
- R9: An edge trigger compares the synchronised value with its value one cycle earlier. The bit then stays set after the edge has passed, until software clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe for the addressed register |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| pad_out | output | 32 | Pad output levels |
| pad_oe | output | 32 | Pad output enables, 1 means drive |
| irq | output | 1 | Combined masked interrupt |

## Verification
The bound checker checks on every cycle that the mask and the output-enable vector change only after a write to their own addresses. It also checks that a status bit never falls unless the previous cycle wrote a 1 to it, and that `irq` is never high while the mask is zero. The sensitivity encodings, the three-cycle delay from pad to status, the re-assertion of a cleared level trigger and the sticky edge capture depend on pad sequences over several cycles. Only the bench's directed and random scenarios can show these, which it does by comparing every register against its own model.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pad_in,
  output logic [W-1:0]  pad_out,
  output logic [W-1:0]  pad_oe,
  output logic          irq
);
  localparam logic [AW-1:0] A_DATA = AW'(5'h00);
  localparam logic [AW-1:0] A_DIR  = AW'(5'h04);
  localparam logic [AW-1:0] A_PAD  = AW'(5'h08);
  localparam logic [AW-1:0] A_CFGL = AW'(5'h0C);
  localparam logic [AW-1:0] A_CFGH = AW'(5'h10);
  localparam logic [AW-1:0] A_MASK = AW'(5'h14);
  localparam logic [AW-1:0] A_STAT = AW'(5'h18);

  logic [W-1:0]   data_q, dir_q, mask_q, stat_q;
  logic [W-1:0]   cfg_lo, cfg_hi;
  logic [W-1:0]   sync1, sync2, prev_q;
  logic [W-1:0]   evt, clr;
  logic [2*W-1:0] cfg;

  assign cfg     = {cfg_hi, cfg_lo};
  assign clr     = (bus_we && bus_addr == A_STAT) ? bus_wdata : '0;
  assign pad_out = data_q;
  assign pad_oe  = dir_q;
  assign irq     = |(stat_q & mask_q);

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic [1:0] mode;
    assign mode = cfg[2*i +: 2];
    always_comb begin
      case (mode)
        2'b00:   evt[i] = ~sync2[i];
        2'b01:   evt[i] =  sync2[i];
        2'b10:   evt[i] =  sync2[i] & ~prev_q[i];
        default: evt[i] = ~sync2[i] &  prev_q[i];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1  <= '0;
      sync2  <= '0;
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      sync1  <= pad_in;
      sync2  <= sync1;
      prev_q <= sync2;
      stat_q <= (stat_q & ~clr) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      dir_q  <= '0;
      cfg_lo <= '0;
      cfg_hi <= '0;
      mask_q <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_DATA:  data_q <= bus_wdata;
        A_DIR:   dir_q  <= bus_wdata;
        A_CFGL:  cfg_lo <= bus_wdata;
        A_CFGH:  cfg_hi <= bus_wdata;
        A_MASK:  mask_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (bus_addr)
      A_DATA:  bus_rdata = (data_q & dir_q) | (sync2 & ~dir_q);
      A_DIR:   bus_rdata = dir_q;
      A_PAD:   bus_rdata = sync2;
      A_CFGL:  bus_rdata = cfg_lo;
      A_CFGH:  bus_rdata = cfg_hi;
      A_MASK:  bus_rdata = mask_q;
      A_STAT:  bus_rdata = stat_q;
      default: bus_rdata = '0;
    endcase
  end
endmodule

module gpio_port_chk #(
  parameter int W  = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic [AW-1:0] bus_addr,
  input logic [W-1:0]  bus_wdata,
  input logic [W-1:0]  pad_oe,
  input logic [W-1:0]  mask_q,
  input logic [W-1:0]  stat_q,
  input logic          irq
);
  logic wr_mask, wr_dir, wr_stat;
  assign wr_mask = bus_we && bus_addr == AW'(5'h14);
  assign wr_dir  = bus_we && bus_addr == AW'(5'h04);
  assign wr_stat = bus_we && bus_addr == AW'(5'h18);

  p_mask_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mask |=> $stable(mask_q));

  p_oe_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_dir |=> $stable(pad_oe));

  p_clear_only_w1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(stat_q) & ~stat_q & ~($past(wr_stat) ? $past(bus_wdata) : '0)) == '0));

  p_irq_needs_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (mask_q != '0));
endmodule

bind gpio_port gpio_port_chk #(.W(W), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pad_oe(pad_oe), .mask_q(mask_q),
  .stat_q(stat_q), .irq(irq)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq;

  int nchk = 0;
  int nerr = 0;
  bit done = 1'b0;

  logic [31:0] m_data, m_dir, m_lo, m_hi, m_mask, m_stat, m_s1, m_s2, m_prev;

  gpio_port uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] f_events(logic [31:0] lo, logic [31:0] hi,
                                           logic [31:0] s, logic [31:0] p);
    logic [63:0] c;
    logic [31:0] e;
    c = {hi, lo};
    for (int i = 0; i < 32; i++) begin
      case (c[2*i +: 2])
        2'b00:   e[i] = ~s[i];
        2'b01:   e[i] =  s[i];
        2'b10:   e[i] =  s[i] & ~p[i];
        default: e[i] = ~s[i] &  p[i];
      endcase
    end
    return e;
  endfunction

  function automatic logic [31:0] f_read(logic [4:0] a);
    case (a)
      5'h00:   return (m_data & m_dir) | (m_s2 & ~m_dir);
      5'h04:   return m_dir;
      5'h08:   return m_s2;
      5'h0C:   return m_lo;
      5'h10:   return m_hi;
      5'h14:   return m_mask;
      5'h18:   return m_stat;
      default: return '0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_data = '0; m_dir = '0; m_lo = '0; m_hi = '0; m_mask = '0;
    m_stat = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
  endtask

  task automatic cyc(bit we, logic [4:0] a, logic [31:0] wd, logic [31:0] pad);
    logic [31:0] e, c;
    bus_we = we; bus_addr = a; bus_wdata = wd; pad_in = pad;
    @(posedge clk);
    e = f_events(m_lo, m_hi, m_s2, m_prev);
    c = (we && a == 5'h18) ? wd : '0;
    m_stat = (m_stat & ~c) | e;
    m_prev = m_s2; m_s2 = m_s1; m_s1 = pad;
    if (we) begin
      case (a)
        5'h00: m_data = wd;
        5'h04: m_dir  = wd;
        5'h0C: m_lo   = wd;
        5'h10: m_hi   = wd;
        5'h14: m_mask = wd;
        default: ;
      endcase
    end
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    bus_we = 1'b0; bus_addr = a; #1; v = bus_rdata;
  endtask

  task automatic check_all();
    logic [31:0] v;
    rd(5'h00, v); chk("R4 data read", v, f_read(5'h00));
    rd(5'h04, v); chk("R1 direction", v, f_read(5'h04));
    rd(5'h08, v); chk("R3 pad status", v, f_read(5'h08));
    rd(5'h0C, v); chk("R6 config low", v, f_read(5'h0C));
    rd(5'h10, v); chk("R6 config high", v, f_read(5'h10));
    rd(5'h14, v); chk("R5 mask", v, f_read(5'h14));
    rd(5'h18, v); chk("R7 status", v, f_read(5'h18));
    chk("R8 irq", {31'b0, irq}, {31'b0, |(m_stat & m_mask)});
    chk("R2 pad_oe", pad_oe, m_dir);
    chk("R2 pad_out", pad_out, m_data);
  endtask

  initial begin
    int cyc_n = 0;
    while (!done && cyc_n < 150000) begin
      @(posedge clk);
      cyc_n++;
    end
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    for (int a = 0; a < 7; a++) begin
      rd(5'(a*4), v); chk("R1 reset value", v, 32'h0);
    end
    chk("R8 irq reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;

    // R6: pads low with default config -> all status set after sync latency
    repeat (3) cyc(0, 5'h00, '0, 32'h0);
    rd(5'h18, v); chk("R6 low-level default sets status", v, 32'hFFFF_FFFF);
    chk("R8 masked capture irq low", {31'b0, irq}, 32'h0);
    cyc(1, 5'h14, 32'h0000_0008, 32'h0);
    chk("R8 irq with mask bit 3", {31'b0, irq}, 32'h1);
    // R7: clear while level persists -> reasserts
    cyc(1, 5'h18, 32'hFFFF_FFFF, 32'h0);
    rd(5'h18, v); chk("R7 level reasserts after clear", v, 32'hFFFF_FFFF);
    // R9: rising edge on all pins
    cyc(1, 5'h0C, 32'hAAAA_AAAA, 32'h0);
    cyc(1, 5'h10, 32'hAAAA_AAAA, 32'h0);
    cyc(1, 5'h18, 32'hFFFF_FFFF, 32'h0);
    rd(5'h18, v); chk("R9 rising config clears", v, 32'h0);
    repeat (4) cyc(0, 5'h00, '0, 32'h0000_0010);
    rd(5'h18, v); chk("R9 rising edge sticky", v, 32'h0000_0010);
    cyc(1, 5'h18, 32'h0, 32'h0000_0010);
    rd(5'h18, v); chk("R7 write zero no effect", v, 32'h0000_0010);
    cyc(1, 5'h18, 32'h0000_0010, 32'h0000_0010);
    repeat (2) cyc(0, 5'h00, '0, 32'h0000_0010);
    rd(5'h18, v); chk("R9 edge gone stays clear", v, 32'h0);
    // falling on pin 4 via config low word 0xFFFFFFFF
    cyc(1, 5'h0C, 32'hFFFF_FFFF, 32'h0000_0010);
    repeat (4) cyc(0, 5'h00, '0, 32'h0);
    rd(5'h18, v); chk("R9 falling edge pin 4", v, 32'h0000_0010);
    // R4/R3: output pin returns latch, pad status returns pad
    cyc(1, 5'h04, 32'h0000_00FF, 32'h0000_0F00);
    cyc(1, 5'h00, 32'h0000_00A5, 32'h0000_0F00);
    repeat (2) cyc(0, 5'h00, '0, 32'h0000_0F00);
    rd(5'h00, v); chk("R4 mixed data read", v, 32'h0000_0FA5);
    rd(5'h08, v); chk("R3 pad status ignores direction", v, 32'h0000_0F00);
    chk("R2 pad_oe follows direction", pad_oe, 32'h0000_00FF);
    check_all();

    for (int n = 0; n < 3000; n++) begin
      bit we;
      logic [4:0] a;
      logic [31:0] pad;
      we = ($urandom % 3) == 0;
      a = 5'(($urandom % 7) * 4);
      pad = (($urandom % 4) == 0) ? $urandom : pad_in;
      cyc(we, a, $urandom, pad);
      check_all();
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'd12345));
  end
endmodule